// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the sweep timing for a CRT-style display: active-low horizontal, vertical and composite sync, a blank strobe and a vertical-retrace interrupt. Every edge is programmed through a byte-wide register file on a small synchronous read/write bus addressed by a 5-bit offset. A horizontal counter advances on a character-clock enable, where one character is eight pixels. A vertical counter advances once per line. Each sync and blank output is a window compare on one of the two counters.

Software fills in the edge registers and then writes the control byte. The control byte has three separate enables: one starts the counters, one lets video through instead of forcing blank, and one passes the retrace interrupt to the `irq` pin. A status byte reports the monitor identity that is strapped on input pins, together with the interrupt-pending flag.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, hsync_n, vsync_n and csync_n read 1, blank reads 1 and irq reads 0. After reset every register at offsets 0x10 and 0x12–0x1F reads back 0x00.
- R2: A write to offset 0x10 or 0x12–0x1F stores the byte. A read returns the byte on bus_rdata one clock after the offset is presented. Offsets 0x00–0x0F read 0x00, and writes to them have no effect.
- R3: Offset 0x11 reads {pending, mon_res[2:0], mon_id[3:0]}, and the pins are sampled every clock. Writes to 0x11 are ignored.
- R4: The horizontal counter runs from 0 to N−1, where N is the byte at 0x14. The line is horizontally blanked while the counter is below the byte at 0x15.
- R5: The vertical counter steps at each line wrap. It runs from 0 to F−1, where F = {byte 0x19, byte 0x1A} as a 16-bit line count. The line is vertically blanked while the counter is below the byte at 0x1B.
- R6: hsync_n is low while the horizontal count c satisfies byte0x16 ≤ c < byte0x17. vsync_n is low while the vertical count v satisfies byte0x1C ≤ v < byte0x1D. csync_n equals hsync_n, except on vsync lines, where it is low for byte0x16 ≤ c < byte0x18. All outputs are registered: they reflect the counter values one clock earlier.
- R7: Control bit 5 (timing enable) at 0 holds both counters at 0, holds all sync outputs at 1 and holds blank at 1.
- R8: Control bit 6 (video enable) at 0 forces blank to 1, while the sync outputs keep running as long as bit 5 is set. blank is 1 during any horizontal or vertical blank interval.
- R9: pending is set at each rising edge of vertical blank, which includes the enabling of timing. A write to 0x10 with bit 7 low clears pending. If a set and a clear fall in the same clock, the set wins.
- R10: irq is 1 one clock after pending and control bit 7 (interrupt enable) are both 1, and 0 otherwise.
- R11: Both counters advance only in clocks where char_ce is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_ce | input | 1 | Character-clock enable for the counters |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mon_id | input | 4 | Monitor identity strap |
| mon_res | input | 3 | Monitor resolution code strap |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank | output | 1 | Blank strobe, active high |
| irq | output | 1 | Vertical-retrace interrupt |

## Verification
Two events can land on the same clock: the vertical-blank rising edge that sets pending, and a control write with bit 7 low that clears it. The bench counts clocks from a known timing-enable edge. It places one clearing write well away from any retrace and checks that pending reads 0. It then times a second clearing write to land on the exact clock where the frame wraps into vertical blank. That second case is judged correct only if the status byte still shows pending set two clocks later.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int BYTE_W = 8;

  // register slots within the upper half of the offset space
  localparam logic [3:0] IDX_CTRL  = 4'h0;
  localparam logic [3:0] IDX_STAT  = 4'h1;
  localparam logic [3:0] IDX_HB_S  = 4'h4;
  localparam logic [3:0] IDX_HB_E  = 4'h5;
  localparam logic [3:0] IDX_HS_S  = 4'h6;
  localparam logic [3:0] IDX_HS_E  = 4'h7;
  localparam logic [3:0] IDX_CS_E  = 4'h8;
  localparam logic [3:0] IDX_VB_SH = 4'h9;
  localparam logic [3:0] IDX_VB_SL = 4'hA;
  localparam logic [3:0] IDX_VB_E  = 4'hB;
  localparam logic [3:0] IDX_VS_S  = 4'hC;
  localparam logic [3:0] IDX_VS_E  = 4'hD;

  // control byte bit positions
  localparam int CB_IEN = 7;
  localparam int CB_VEN = 6;
  localparam int CB_TEN = 5;

  typedef struct packed {
    logic [BYTE_W-1:0]   hb_start;
    logic [BYTE_W-1:0]   hb_end;
    logic [BYTE_W-1:0]   hs_start;
    logic [BYTE_W-1:0]   hs_end;
    logic [BYTE_W-1:0]   cs_end;
    logic [2*BYTE_W-1:0] vb_start;
    logic [BYTE_W-1:0]   vb_end;
    logic [BYTE_W-1:0]   vs_start;
    logic [BYTE_W-1:0]   vs_end;
  } timing_cfg_t;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
  import rtg_pkg::*;
#(
  parameter int AW   = 5,
  parameter int DW   = BYTE_W,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [3:0]    mon_id,
  input  logic [2:0]    mon_res,
  input  logic          pend,
  output logic          ien,
  output logic          ven,
  output logic          ten,
  output timing_cfg_t   cfg,
  output logic          clr_req
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];
  logic [DW-2:0] status_q;
  logic          win;
  logic [IW-1:0] idx;

  assign win = addr[AW-1];
  assign idx = addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr && win && idx != IDX_STAT) begin
      regs[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= {mon_res, mon_id};
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (!win)            rdata <= '0;
    else if (idx == IDX_STAT) rdata <= {pend, status_q};
    else                      rdata <= regs[idx];
  end

  assign ien = regs[IDX_CTRL][CB_IEN];
  assign ven = regs[IDX_CTRL][CB_VEN];
  assign ten = regs[IDX_CTRL][CB_TEN];

  assign clr_req = wr && win && (idx == IDX_CTRL) && !wdata[CB_IEN];

  assign cfg.hb_start = regs[IDX_HB_S];
  assign cfg.hb_end   = regs[IDX_HB_E];
  assign cfg.hs_start = regs[IDX_HS_S];
  assign cfg.hs_end   = regs[IDX_HS_E];
  assign cfg.cs_end   = regs[IDX_CS_E];
  assign cfg.vb_start = {regs[IDX_VB_SH], regs[IDX_VB_SL]};
  assign cfg.vb_end   = regs[IDX_VB_E];
  assign cfg.vs_start = regs[IDX_VS_S];
  assign cfg.vs_end   = regs[IDX_VS_E];

  // R3
  stat_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (win && idx == IDX_STAT) |=> rdata[DW-2:0] == $past(status_q));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int HW = 8,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ten,
  input  logic          ce,
  input  logic [HW-1:0] h_per,
  input  logic [VW-1:0] v_per,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt
);
  logic [HW:0] h_inc;
  logic [VW:0] v_inc;
  logic        h_last;
  logic        v_last;

  assign h_inc  = {1'b0, h_cnt} + (HW+1)'(1);
  assign v_inc  = {1'b0, v_cnt} + (VW+1)'(1);
  assign h_last = h_inc >= {1'b0, h_per};
  assign v_last = v_inc >= {1'b0, v_per};

  always_ff @(posedge clk) begin
    if (rst || !ten) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (ce) begin
      if (h_last) begin
        h_cnt <= '0;
        v_cnt <= v_last ? '0 : v_inc[VW-1:0];
      end else begin
        h_cnt <= h_inc[HW-1:0];
      end
    end
  end

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ten && !ce) |=> ($stable(h_cnt) && $stable(v_cnt)));

  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ten |=> (h_cnt == '0 && v_cnt == '0));
endmodule

// File: rtl/rtg_sync_gen.sv
module rtg_sync_gen #(
  parameter int HW = 8,
  parameter int VW = 16,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ten,
  input  logic          ven,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic [EW-1:0] hb_end,
  input  logic [EW-1:0] hs_start,
  input  logic [EW-1:0] hs_end,
  input  logic [EW-1:0] cs_end,
  input  logic [EW-1:0] vb_end,
  input  logic [EW-1:0] vs_start,
  input  logic [EW-1:0] vs_end,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          csync_n,
  output logic          blank,
  output logic          vb_rise
);
  logic in_hb, in_vb, in_hs, in_vs, in_cs, wide_cs;
  logic vb_now, vb_q;

  assign in_hb   = h_cnt < HW'(hb_end);
  assign in_vb   = v_cnt < VW'(vb_end);
  assign in_hs   = (h_cnt >= HW'(hs_start)) && (h_cnt < HW'(hs_end));
  assign in_vs   = (v_cnt >= VW'(vs_start)) && (v_cnt < VW'(vs_end));
  assign wide_cs = (h_cnt >= HW'(hs_start)) && (h_cnt < HW'(cs_end));
  assign in_cs   = in_vs ? wide_cs : in_hs;

  assign vb_now  = ten && in_vb;
  assign vb_rise = vb_now && !vb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      csync_n <= 1'b1;
      blank   <= 1'b1;
      vb_q    <= 1'b0;
    end else begin
      hsync_n <= !(ten && in_hs);
      vsync_n <= !(ten && in_vs);
      csync_n <= !(ten && in_cs);
      blank   <= !ten || !ven || in_hb || in_vb;
      vb_q    <= vb_now;
    end
  end

  // R8
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ven |=> blank);

  // R7
  sync_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ten |=> (hsync_n && vsync_n && csync_n && blank));
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq (
  input  logic clk,
  input  logic rst,
  input  logic vb_rise,
  input  logic clr_req,
  input  logic ien,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (vb_rise) pending <= 1'b1;
    else if (clr_req) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pending && ien;
  end

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    vb_rise |=> pending);

  // R9
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !vb_rise) |=> !pending);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = BYTE_W,
  parameter int HW = BYTE_W,
  parameter int VW = 2*BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_ce,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    mon_id,
  input  logic [2:0]    mon_res,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          csync_n,
  output logic          blank,
  output logic          irq
);
  timing_cfg_t   cfg;
  logic          ien, ven, ten, clr_req, pending, vb_rise;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;

  rtg_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .mon_id(mon_id), .mon_res(mon_res), .pend(pending),
    .ien(ien), .ven(ven), .ten(ten), .cfg(cfg), .clr_req(clr_req)
  );

  rtg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .ten(ten), .ce(char_ce),
    .h_per(HW'(cfg.hb_start)), .v_per(VW'(cfg.vb_start)),
    .h_cnt(h_cnt), .v_cnt(v_cnt)
  );

  rtg_sync_gen #(.HW(HW), .VW(VW), .EW(BYTE_W)) u_sync (
    .clk(clk), .rst(rst), .ten(ten), .ven(ven),
    .h_cnt(h_cnt), .v_cnt(v_cnt),
    .hb_end(cfg.hb_end), .hs_start(cfg.hs_start), .hs_end(cfg.hs_end),
    .cs_end(cfg.cs_end), .vb_end(cfg.vb_end), .vs_start(cfg.vs_start),
    .vs_end(cfg.vs_end),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n),
    .blank(blank), .vb_rise(vb_rise)
  );

  rtg_irq u_irq (
    .clk(clk), .rst(rst), .vb_rise(vb_rise), .clr_req(clr_req),
    .ien(ien), .pending(pending), .irq(irq)
  );
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_ce = 1'b1;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] mon_id = 4'h1;
  logic [2:0] mon_res = 3'h4;
  logic hsync_n, vsync_n, csync_n, blank, irq;

  always #2 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .char_ce(char_ce), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mon_id(mon_id), .mon_res(mon_res), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .csync_n(csync_n), .blank(blank), .irq(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int c_hper, c_hbe, c_hss, c_hse, c_cse, c_vper, c_vbe, c_vss, c_vse;
  bit c_ven;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic base_cfg();
    c_hper = 10; c_hbe = 2; c_hss = 4; c_hse = 6; c_cse = 8;
    c_vper = 6;  c_vbe = 1; c_vss = 2; c_vse = 3; c_ven = 1;
  endtask

  task automatic load_cfg();
    bus_write(5'h14, 8'(c_hper));
    bus_write(5'h15, 8'(c_hbe));
    bus_write(5'h16, 8'(c_hss));
    bus_write(5'h17, 8'(c_hse));
    bus_write(5'h18, 8'(c_cse));
    bus_write(5'h19, 8'(c_vper >> 8));
    bus_write(5'h1a, 8'(c_vper));
    bus_write(5'h1b, 8'(c_vbe));
    bus_write(5'h1c, 8'(c_vss));
    bus_write(5'h1d, 8'(c_vse));
  endtask

  // returns at the negedge after the enabling edge
  task automatic start_timing(logic [7:0] ctrl);
    bus_write(5'h10, 8'h00);
    bus_write(5'h10, ctrl);
  endtask

  // outputs after edge E+k reflect counters after E+k-1, i.e. idx = k-1
  task automatic compare_run(int ncyc);
    for (int k = 1; k <= ncyc; k++) begin
      int idx, h, v;
      logic hs, vs, cs, bl;
      @(negedge clk);
      idx = k - 1;
      h  = idx % c_hper;
      v  = (idx / c_hper) % c_vper;
      hs = (h >= c_hss) && (h < c_hse);
      vs = (v >= c_vss) && (v < c_vse);
      cs = vs ? ((h >= c_hss) && (h < c_cse)) : hs;
      bl = !c_ven || (h < c_hbe) || (v < c_vbe);
      check("R6 hsync_n",        8'(hsync_n), 8'(!hs));
      check("R5/R6 vsync_n",     8'(vsync_n), 8'(!vs));
      check("R6 csync_n",        8'(csync_n), 8'(!cs));
      check("R4/R5/R8 blank",    8'(blank),   8'(bl));
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 hsync_n", 8'(hsync_n), 8'h1);
    check("R1 vsync_n", 8'(vsync_n), 8'h1);
    check("R1 csync_n", 8'(csync_n), 8'h1);
    check("R1 blank",   8'(blank),   8'h1);
    check("R1 irq",     8'(irq),     8'h0);
    bus_read(5'h10, d); check("R1 ctrl", d, 8'h00);
    bus_read(5'h1a, d); check("R1 vblank low", d, 8'h00);
    bus_read(5'h11, d); check("R3 status", d, 8'h41);
    bus_write(5'h11, 8'hff);
    bus_read(5'h11, d); check("R3 status write ignored", d, 8'h41);
    mon_id = 4'h2; mon_res = 3'h6;
    @(negedge clk);
    bus_read(5'h11, d); check("R3 status pins", d, 8'h62);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    for (int a = 5'h12; a <= 5'h1f; a++) bus_write(5'(a), 8'(8'h50 + a));
    for (int a = 5'h12; a <= 5'h1f; a++) begin
      bus_read(5'(a), d);
      check("R2 readback", d, 8'(8'h50 + a));
    end
    bus_write(5'h10, 8'h0f);
    bus_read(5'h10, d); check("R2 ctrl readback", d, 8'h0f);
    bus_write(5'h07, 8'haa);
    bus_read(5'h07, d); check("R2 low offset", d, 8'h00);
  endtask

  task automatic t_timing_off();
    base_cfg(); load_cfg();
    bus_write(5'h10, 8'h40);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R7 syncs idle", 8'({hsync_n, vsync_n, csync_n}), 8'h7);
      check("R7 blank held", 8'(blank), 8'h1);
    end
  endtask

  task automatic t_raster();
    base_cfg(); load_cfg();
    start_timing(8'h60);
    compare_run(130);
  endtask

  task automatic t_video_off();
    base_cfg(); c_ven = 0; load_cfg();
    start_timing(8'h20);
    compare_run(70);
  endtask

  task automatic t_tall_frame();
    base_cfg(); c_vper = 258; c_vss = 200; c_vse = 201; load_cfg();
    start_timing(8'h60);
    compare_run(2600);
  endtask

  task automatic t_char_ce();
    base_cfg(); load_cfg();
    start_timing(8'h20);
    repeat (4) @(negedge clk);
    char_ce = 1'b0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      check("R11 counter frozen hsync_n", 8'(hsync_n), 8'h0);
    end
    char_ce = 1'b1;
  endtask

  task automatic t_pending();
    base_cfg(); load_cfg();
    start_timing(8'h20);
    bus_addr = 5'h11;
    repeat (2) @(negedge clk);
    check("R9 set on enable", 8'(bus_rdata[7]), 8'h1);
    repeat (27) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 8'h20;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h11;
    repeat (15) @(negedge clk);
    check("R9 cleared", 8'(bus_rdata[7]), 8'h0);
    repeat (15) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 8'h20;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h11;
    repeat (2) @(negedge clk);
    check("R9 set wins over clear", 8'(bus_rdata[7]), 8'h1);
  endtask

  task automatic t_irq();
    check("R10 masked", 8'(irq), 8'h0);
    bus_write(5'h10, 8'ha0);
    @(negedge clk);
    check("R10 irq raised", 8'(irq), 8'h1);
    bus_write(5'h10, 8'h20);
    @(negedge clk);
    check("R10 irq dropped", 8'(irq), 8'h0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_timing_off();
    t_raster();
    t_video_off();
    t_tall_frame();
    t_char_ce();
    t_pending();
    t_irq();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule